// File: doc/BRIEF.md
# Sector Protection Bit Array

This block models the device-side write-protection logic of a parallel NOR flash. It keeps one non-volatile protection bit for each sector. It watches the bus write cycles (strobe, address, data) for a three-write unlock handshake that opens a protection command mode. Inside that mode, software can set the bit of a single sector, clear every bit at once, or set a freeze latch. While the freeze latch is set, the bit array cannot change until the next hardware reset. A query port returns the protection state of any sector at once.

The protection bits live in their own reset domain. They are cleared only by a power-on reset. The hardware reset returns the freeze latch, the command decoder, the busy timer and the error flag to their idle values and leaves the bits alone. Program and clear-all start a busy window whose length is a parameter. Commands that arrive during that window are dropped. An ordinary array write to a protected sector, made outside any command sequence, raises a sticky error flag.

Top module: `sector_prot_array`

## Requirements
- R1: Writing 0xAA to unlock address A (default 0x555), then 0x55 to unlock address B (default 0x2AA), then 0xC0 to address A sets `mode_active` to 1.
- R2: A write that does not match the next step of the unlock handshake sends the decoder back to idle (`mode_active` stays 0) and changes no protection bit.
- R3: In protection mode, 0xA0 to address A followed by 0x00 to any address sets only the bit of the sector that address falls in. The sector index is the top log2(SECTORS) address bits. Any other data in the second write changes nothing.
- R4: In protection mode, 0x80 to address A followed by 0x30 clears every protection bit. Any other data in the second write changes nothing. No command clears a single bit.
- R5: In protection mode, 0x90 to address A followed by 0x00 to address A returns the decoder to idle, with `mode_active` set to 0.
- R6: In protection mode, 0x50 to address A sets `frozen`. While `frozen` is 1, program and clear-all leave every bit unchanged and do not start the busy window.
- R7: Hardware reset clears `frozen`, `mode_active`, `busy` and `wr_err` and keeps all protection bits. Power-on reset also clears every protection bit.
- R8: An accepted program or clear-all holds `busy` high for exactly BUSY_CYCLES cycles, starting after the clock edge that takes the command. Writes taken while `busy` is high are ignored.
- R9: A write taken in the idle state that is not the start of the unlock handshake raises `wr_err` if its sector is protected, and `wr_err` then stays high until reset. A write of this kind to an unprotected sector leaves `wr_err` unchanged.
- R10: `qry_prot` is the current protection bit of the sector selected by `qry_sector`, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears everything |
| hw_rst_n | input | 1 | Hardware reset, active low, asynchronous; keeps protection bits |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| qry_sector | input | log2(SECTORS) | Sector to query |
| qry_prot | output | 1 | Protection bit of the queried sector |
| mode_active | output | 1 | Decoder is in protection mode or in one of its armed states |
| busy | output | 1 | Program or clear-all window is running |
| frozen | output | 1 | Freeze latch; the bit array is locked |
| wr_err | output | 1 | Sticky flag for a write to a protected sector |

## Verification
The assertions assume that the strobe lasts one cycle for each bus write, and that the power-on reset is applied before any reliance on the bit array. They also assume that a reset is not released in the same cycle that a write is taken. The bench drives every write as a single-cycle pulse, set up at a falling edge. It releases both resets on falling edges while the strobe is low, and it reads the query port only in the low half of the clock, away from the edge where the bits change. Writes made inside the busy window are placed there on purpose, and their being dropped is then shown through a later command that would otherwise have had a visible effect.

// File: rtl/sp_pkg.sv
package sp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNL1,
        ST_UNL2,
        ST_PMODE,
        ST_PROG_ARM,
        ST_CLR_ARM,
        ST_EXIT_ARM
    } sp_state_e;

    localparam logic [7:0] CMD_KEY1     = 8'hAA;
    localparam logic [7:0] CMD_KEY2     = 8'h55;
    localparam logic [7:0] CMD_ENTER    = 8'hC0;
    localparam logic [7:0] CMD_PROG     = 8'hA0;
    localparam logic [7:0] CMD_PROG_GO  = 8'h00;
    localparam logic [7:0] CMD_CLR      = 8'h80;
    localparam logic [7:0] CMD_CLR_GO   = 8'h30;
    localparam logic [7:0] CMD_EXIT     = 8'h90;
    localparam logic [7:0] CMD_EXIT_GO  = 8'h00;
    localparam logic [7:0] CMD_FREEZE   = 8'h50;

    typedef struct packed {
        sp_state_e state;
    } dec_regs_t;

endpackage

// File: rtl/sp_cmd_decoder.sv
module sp_cmd_decoder
    import sp_pkg::*;
#(
    parameter int          ADDR_W = 12,
    parameter int          SECT_W = 3,
    parameter logic [11:0] UNL_A  = 12'h555,
    parameter logic [11:0] UNL_B  = 12'h2AA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              busy,
    output logic              mode_active,
    output logic              set_pulse,
    output logic              clr_pulse,
    output logic              frz_pulse,
    output logic              arr_wr_pulse,
    output logic [SECT_W-1:0] sect_idx
);

    dec_regs_t dec_d, dec_q;
    logic      hit_a, hit_b, take;

    assign hit_a    = (wr_addr == ADDR_W'(UNL_A));
    assign hit_b    = (wr_addr == ADDR_W'(UNL_B));
    assign take     = wr_en && !busy;
    assign sect_idx = wr_addr[ADDR_W-1 -: SECT_W];

    always_comb begin
        dec_d        = dec_q;
        set_pulse    = 1'b0;
        clr_pulse    = 1'b0;
        frz_pulse    = 1'b0;
        arr_wr_pulse = 1'b0;
        if (take) begin
            case (dec_q.state)
                ST_IDLE: begin
                    if (hit_a && wr_data == CMD_KEY1) dec_d.state = ST_UNL1;
                    else                              arr_wr_pulse = 1'b1;
                end
                ST_UNL1:
                    dec_d.state = (hit_b && wr_data == CMD_KEY2) ? ST_UNL2 : ST_IDLE;
                ST_UNL2:
                    dec_d.state = (hit_a && wr_data == CMD_ENTER) ? ST_PMODE : ST_IDLE;
                ST_PMODE: begin
                    if (hit_a) begin
                        case (wr_data)
                            CMD_PROG:   dec_d.state = ST_PROG_ARM;
                            CMD_CLR:    dec_d.state = ST_CLR_ARM;
                            CMD_EXIT:   dec_d.state = ST_EXIT_ARM;
                            CMD_FREEZE: frz_pulse   = 1'b1;
                            default:    dec_d.state = ST_PMODE;
                        endcase
                    end
                end
                ST_PROG_ARM: begin
                    dec_d.state = ST_PMODE;
                    if (wr_data == CMD_PROG_GO) set_pulse = 1'b1;
                end
                ST_CLR_ARM: begin
                    dec_d.state = ST_PMODE;
                    if (wr_data == CMD_CLR_GO) clr_pulse = 1'b1;
                end
                ST_EXIT_ARM:
                    dec_d.state = (hit_a && wr_data == CMD_EXIT_GO) ? ST_IDLE : ST_PMODE;
                default:
                    dec_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '{state: ST_IDLE};
        else        dec_q <= dec_d;
    end

    assign mode_active = (dec_q.state == ST_PMODE)    || (dec_q.state == ST_PROG_ARM) ||
                         (dec_q.state == ST_CLR_ARM)  || (dec_q.state == ST_EXIT_ARM);

endmodule

// File: rtl/sp_busy_timer.sv
module sp_busy_timer #(
    parameter int BUSY_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)             cnt_d = CNT_W'(BUSY_CYCLES);
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/sp_prot_array.sv
module sp_prot_array #(
    parameter int SECTORS = 8,
    parameter int SECT_W  = 3
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               rst_n,
    input  logic               set_pulse,
    input  logic               clr_pulse,
    input  logic               frz_pulse,
    input  logic               arr_wr_pulse,
    input  logic [SECT_W-1:0]  sect_idx,
    input  logic [SECT_W-1:0]  qry_sector,
    output logic [SECTORS-1:0] prot_bits,
    output logic               qry_prot,
    output logic               frozen,
    output logic               wr_err
);

    typedef struct packed {
        logic frozen;
        logic err;
    } vol_t;

    logic [SECTORS-1:0] bits_d, bits_q;
    vol_t               vol_d, vol_q;

    always_comb begin
        bits_d = bits_q;
        vol_d  = vol_q;
        if (!vol_q.frozen) begin
            if (clr_pulse)      bits_d = '0;
            else if (set_pulse) bits_d[sect_idx] = 1'b1;
        end
        if (frz_pulse) vol_d.frozen = 1'b1;
        if (arr_wr_pulse && bits_q[sect_idx]) vol_d.err = 1'b1;
    end

    // persistent storage: only power-on reset touches it
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vol_q <= '{frozen: 1'b0, err: 1'b0};
        else        vol_q <= vol_d;
    end

    assign prot_bits = bits_q;
    assign qry_prot  = bits_q[qry_sector];
    assign frozen    = vol_q.frozen;
    assign wr_err    = vol_q.err;

endmodule

// File: rtl/sector_prot_array.sv
module sector_prot_array
    import sp_pkg::*;
#(
    parameter int          ADDR_W      = 12,
    parameter int          SECTORS     = 8,
    parameter int          BUSY_CYCLES = 4,
    parameter logic [11:0] UNL_A       = 12'h555,
    parameter logic [11:0] UNL_B       = 12'h2AA,
    localparam int         SECT_W      = $clog2(SECTORS)
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              hw_rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [SECT_W-1:0] qry_sector,
    output logic              qry_prot,
    output logic              mode_active,
    output logic              busy,
    output logic              frozen,
    output logic              wr_err
);

    logic               rst_all_n;
    logic               set_pulse, clr_pulse, frz_pulse, arr_wr_pulse;
    logic [SECT_W-1:0]  sect_idx;
    logic [SECTORS-1:0] prot_bits;
    logic               op_start;

    assign rst_all_n = por_n & hw_rst_n;
    assign op_start  = (set_pulse | clr_pulse) & ~frozen;

    sp_cmd_decoder #(
        .ADDR_W (ADDR_W),
        .SECT_W (SECT_W),
        .UNL_A  (UNL_A),
        .UNL_B  (UNL_B)
    ) u_dec (
        .clk          (clk),
        .rst_n        (rst_all_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .busy         (busy),
        .mode_active  (mode_active),
        .set_pulse    (set_pulse),
        .clr_pulse    (clr_pulse),
        .frz_pulse    (frz_pulse),
        .arr_wr_pulse (arr_wr_pulse),
        .sect_idx     (sect_idx)
    );

    sp_busy_timer #(
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_all_n),
        .start (op_start),
        .busy  (busy)
    );

    sp_prot_array #(
        .SECTORS (SECTORS),
        .SECT_W  (SECT_W)
    ) u_arr (
        .clk          (clk),
        .por_n        (por_n),
        .rst_n        (rst_all_n),
        .set_pulse    (set_pulse),
        .clr_pulse    (clr_pulse),
        .frz_pulse    (frz_pulse),
        .arr_wr_pulse (arr_wr_pulse),
        .sect_idx     (sect_idx),
        .qry_sector   (qry_sector),
        .prot_bits    (prot_bits),
        .qry_prot     (qry_prot),
        .frozen       (frozen),
        .wr_err       (wr_err)
    );

endmodule

// File: rtl/sp_checker.sv
module sp_checker #(
    parameter int SECTORS = 8
) (
    input logic               clk,
    input logic               por_n,
    input logic               hw_rst_n,
    input logic               wr_en,
    input logic               busy,
    input logic               mode_active,
    input logic               frozen,
    input logic               wr_err,
    input logic [SECTORS-1:0] prot_bits
);

    // R6
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!por_n || !hw_rst_n)
        frozen |=> $stable(prot_bits))
        else $error("bits changed while frozen");

    // R4
    clear_all_only_chk: assert property (@(posedge clk) disable iff (!por_n || !hw_rst_n)
        (|($past(prot_bits) & ~prot_bits)) |-> (prot_bits == '0))
        else $error("single protection bit was cleared");

    // R2
    idle_no_change_chk: assert property (@(posedge clk) disable iff (!por_n || !hw_rst_n)
        !mode_active |=> $stable(prot_bits))
        else $error("bits changed outside protection mode");

    // R8
    busy_drop_chk: assert property (@(posedge clk) disable iff (!por_n || !hw_rst_n)
        (busy && wr_en) |=> ($stable(prot_bits) && $stable(mode_active) && $stable(frozen)))
        else $error("write taken while busy");

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!por_n || !hw_rst_n)
        wr_err |=> wr_err)
        else $error("error flag dropped without reset");

    // R6
    freeze_sticky_chk: assert property (@(posedge clk) disable iff (!por_n || !hw_rst_n)
        frozen |=> frozen)
        else $error("freeze latch dropped without reset");

endmodule

bind sector_prot_array sp_checker #(.SECTORS(SECTORS)) u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .hw_rst_n    (hw_rst_n),
    .wr_en       (wr_en),
    .busy        (busy),
    .mode_active (mode_active),
    .frozen      (frozen),
    .wr_err      (wr_err),
    .prot_bits   (prot_bits)
);

// File: tb/sector_prot_array_tb.sv
module sector_prot_array_tb;

    localparam int ADDR_W      = 12;
    localparam int SECTORS     = 8;
    localparam int SECT_W      = 3;
    localparam int BUSY_CYCLES = 4;
    localparam logic [ADDR_W-1:0] A_ADDR = 12'h555;
    localparam logic [ADDR_W-1:0] B_ADDR = 12'h2AA;

    logic              clk = 1'b0;
    logic              por_n = 1'b0;
    logic              hw_rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic [SECT_W-1:0] qry_sector = '0;
    logic              qry_prot, mode_active, busy, frozen, wr_err;

    always #10 clk = ~clk;

    sector_prot_array #(
        .ADDR_W      (ADDR_W),
        .SECTORS     (SECTORS),
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_dut (
        .clk         (clk),
        .por_n       (por_n),
        .hw_rst_n    (hw_rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .qry_sector  (qry_sector),
        .qry_prot    (qry_prot),
        .mode_active (mode_active),
        .busy        (busy),
        .frozen      (frozen),
        .wr_err      (wr_err)
    );

    typedef enum {K_MODE, K_BUSY, K_FROZEN, K_ERR, K_BITS} kind_e;
    typedef struct {
        string req;
        kind_e kind;
        int    exp;
    } item_t;

    item_t q[$];
    bit    mon_active = 1'b0;
    int    n_chk = 0;
    int    n_err = 0;

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected items and measures the outputs in the low clock phase
    initial begin
        forever begin
            item_t it;
            int    v;
            wait (q.size() > 0);
            mon_active = 1'b1;
            it = q.pop_front();
            #1;
            case (it.kind)
                K_MODE:   v = int'(mode_active);
                K_BUSY:   v = int'(busy);
                K_FROZEN: v = int'(frozen);
                K_ERR:    v = int'(wr_err);
                default: begin
                    v = 0;
                    for (int s = 0; s < SECTORS; s++) begin
                        qry_sector = SECT_W'(s);
                        #1;
                        if (qry_prot) v = v | (1 << s);
                    end
                end
            endcase
            check(it.req, v, it.exp);
            mon_active = 1'b0;
        end
    end

    task automatic expect_item(string req, kind_e k, int exp);
        item_t it;
        it.req  = req;
        it.kind = k;
        it.exp  = exp;
        q.push_back(it);
        wait (q.size() == 0 && !mon_active);
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic count_busy(string req, int exp);
        int n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
        check(req, n, exp);
    endtask

    task automatic enter_mode();
        wr(A_ADDR, 8'hAA);
        wr(B_ADDR, 8'h55);
        wr(A_ADDR, 8'hC0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        #(20 * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        por_n    = 1'b1;
        hw_rst_n = 1'b1;
        @(negedge clk);

        // reset state, R7 / R10
        expect_item("R7 mode after reset", K_MODE, 0);
        expect_item("R7 busy after reset", K_BUSY, 0);
        expect_item("R7 frozen after reset", K_FROZEN, 0);
        expect_item("R7 err after reset", K_ERR, 0);
        expect_item("R10 bits after reset", K_BITS, 'h00);

        // R1 entry
        enter_mode();
        expect_item("R1 mode entered", K_MODE, 1);

        // R3 program sector 3, R8 busy length
        wr(A_ADDR, 8'hA0);
        wr(12'h610, 8'h00);
        count_busy("R8 busy length after program", BUSY_CYCLES);
        expect_item("R3 sector 3 set", K_BITS, 'h08);

        // R8 write during busy is dropped
        wr(A_ADDR, 8'hA0);
        wr(12'hC20, 8'h00);
        wr(A_ADDR, 8'hA0);          // arrives while busy: dropped
        wait_idle();
        wr(12'h004, 8'h00);         // would set sector 0 if the arm had been taken
        expect_item("R8 busy write dropped", K_BITS, 'h48);
        expect_item("R10 query after two programs", K_BITS, 'h48);

        // R3 wrong data in second program write
        wr(A_ADDR, 8'hA0);
        wr(12'h008, 8'h11);
        expect_item("R3 wrong program data ignored", K_BITS, 'h48);
        expect_item("R8 no busy after ignored program", K_BUSY, 0);

        // R5 exit
        wr(A_ADDR, 8'h90);
        wr(A_ADDR, 8'h00);
        expect_item("R5 mode left", K_MODE, 0);

        // R9 idle writes
        wr(12'h010, 8'h12);
        expect_item("R9 unprotected write no error", K_ERR, 0);
        wr(12'h610, 8'h34);
        expect_item("R9 protected write raises error", K_ERR, 1);
        wr(12'h020, 8'h56);
        expect_item("R9 error is sticky", K_ERR, 1);

        // R2 broken handshakes
        wr(A_ADDR, 8'hAA);
        wr(B_ADDR, 8'h12);
        wr(B_ADDR, 8'h55);
        wr(A_ADDR, 8'hC0);
        expect_item("R2 bad second step", K_MODE, 0);
        wr(A_ADDR, 8'hAA);
        wr(B_ADDR, 8'h55);
        wr(A_ADDR, 8'hC1);
        expect_item("R2 bad third step", K_MODE, 0);
        expect_item("R2 bits untouched", K_BITS, 'h48);

        // R7 hardware reset keeps bits
        @(negedge clk);
        hw_rst_n = 1'b0;
        @(negedge clk);
        hw_rst_n = 1'b1;
        expect_item("R7 err cleared by hw reset", K_ERR, 0);
        expect_item("R7 bits kept over hw reset", K_BITS, 'h48);

        // R4 clear-all
        enter_mode();
        wr(A_ADDR, 8'h80);
        wr(12'h000, 8'h31);
        expect_item("R4 wrong clear data ignored", K_BITS, 'h48);
        wr(A_ADDR, 8'h80);
        wr(12'h000, 8'h30);
        count_busy("R8 busy length after clear", BUSY_CYCLES);
        expect_item("R4 all bits cleared", K_BITS, 'h00);

        // R6 freeze
        wr(A_ADDR, 8'hA0);
        wr(12'h200, 8'h00);
        wait_idle();
        expect_item("R3 sector 1 set", K_BITS, 'h02);
        wr(A_ADDR, 8'h50);
        expect_item("R6 frozen set", K_FROZEN, 1);
        wr(A_ADDR, 8'hA0);
        wr(12'h400, 8'h00);
        expect_item("R6 no busy when frozen", K_BUSY, 0);
        expect_item("R6 program blocked", K_BITS, 'h02);
        wr(A_ADDR, 8'h80);
        wr(12'h000, 8'h30);
        expect_item("R6 clear blocked", K_BITS, 'h02);

        // R7 hardware reset releases freeze
        @(negedge clk);
        hw_rst_n = 1'b0;
        @(negedge clk);
        hw_rst_n = 1'b1;
        expect_item("R7 freeze cleared", K_FROZEN, 0);
        expect_item("R7 mode cleared", K_MODE, 0);
        expect_item("R7 bits kept after freeze reset", K_BITS, 'h02);

        // R7 power-on reset clears bits
        @(negedge clk);
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        expect_item("R7 bits cleared by power-on", K_BITS, 'h00);

        summary();
        $finish;
    end

endmodule